// File: doc/BRIEF.md
# Flag offset loader

This block keeps the two threshold values that a FIFO's status logic compares against its fill level: the almost-empty offset and the almost-full offset. Both registers share one width (`OFS_W`, 17 bits by default), and each splits into a low half of `LO_W = ceil(OFS_W/2)` bits and a high half that holds the remaining `HI_W` bits.

An initialisation strobe fills both registers with one of four fixed default thresholds, chosen by a two-bit selector. Software can then overwrite the thresholds in one of two ways. The first is a parallel path that works in half-words: a single rotation pointer steps through the four halves in a fixed order, and reads use the same pointer to return the halves in that order. The second is a serial path that takes one bit per clock into a single chain, which covers the empty offset first and then the full offset.

The two offsets drive the outputs straight from their registers, so the comparison logic downstream sees a stable value.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst_n` is low, both offsets and `rdata` are zero. The rotation pointer and the serial position return to their start.
- R2: A cycle with `cfg_init` high loads both offsets with the default picked by `dflt_sel`: 0 gives 7, 1 gives 31, 2 gives 63, 3 gives 127. The same cycle returns the rotation pointer and the serial position to their start. `cfg_init` takes priority over every other input.
- R3: A cycle with `ld_en` and `wr_en` both high writes one half and advances the rotation pointer. The halves are visited in this order: slot 0 is empty-offset bits [LO_W-1:0], slot 1 is empty-offset bits [OFS_W-1:LO_W], slot 2 is full-offset low, slot 3 is full-offset high. After slot 3 the pointer returns to slot 0.
- R4: A cycle with `ld_en` and `rd_en` high and `wr_en` low places the half at the current slot on `rdata`, zero-extended, on the next edge, and advances the pointer. Reads follow the same slot order as writes.
- R5: A low-half write takes only `wdata[LO_W-1:0]`. A high-half write takes only `wdata[HI_W-1:0]`. All other `wdata` bits have no effect.
- R6: A cycle with `ser_en` high and `ld_en` low stores `ser_din` at the serial position and then advances it. Positions 0 to OFS_W-1 are empty-offset bits 0 upward, and positions OFS_W to 2*OFS_W-1 are full-offset bits 0 upward. After position 2*OFS_W-1 the next bit goes to position 0.
- R7: While `ld_en` is high, `ser_en` has no effect on either offset or on the serial position.
- R8: A cycle with `ptr_restart` high returns the rotation pointer to slot 0 and the serial position to 0, and leaves both offsets unchanged.
- R9: Any write appears on the offset outputs at the clock edge that takes it in. A cycle with `ld_en`, `wr_en` and `rd_en` all high performs only the write, and `rdata` holds its value.
- R10: Reads and writes advance one shared pointer, so a write that follows a read lands on the slot after the slot that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_init | input | 1 | Load the default offsets and restart the sequences |
| ptr_restart | input | 1 | Restart the rotation pointer and the serial position |
| dflt_sel | input | 2 | Selects the default offset |
| ld_en | input | 1 | Enables the parallel path and blocks the serial path |
| wr_en | input | 1 | Parallel half write |
| rd_en | input | 1 | Parallel half read |
| wdata | input | BUS_W | Parallel write data |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial data bit |
| rdata | output | BUS_W | Half returned by the last read |
| empty_ofs | output | OFS_W | Almost-empty offset |
| full_ofs | output | OFS_W | Almost-full offset |

## Verification
The hardest state to reach is the serial chain wrapping past its last position. A wrap in the wrong place would corrupt the full offset without any visible sign. The bench streams a deterministic pattern of 2*OFS_W+3 bits, so the last three bits must overwrite the lowest empty-offset bits. It then restarts in the middle of a chain. Restarts and reads are also mixed into the middle of the four-slot rotation, which confirms that the pointer is shared and is cleared in the right place.

// File: rtl/flo_pkg.sv
package flo_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  function automatic slot_e slot_next(input slot_e s);
    logic [1:0] t;
    t = s + 2'd1;
    return slot_e'(t);
  endfunction

endpackage

// File: rtl/flo_rotor.sv
module flo_rotor
  import flo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  step,
  output slot_e slot
);

  slot_e slot_q, slot_d;

  always_comb begin
    slot_d = slot_q;
    if (clr)       slot_d = SLOT_EMPTY_LO;
    else if (step) slot_d = slot_next(slot_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SLOT_EMPTY_LO;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;

  // R8
  rot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> slot == SLOT_EMPTY_LO);

  // R10
  rot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> slot != $past(slot));

endmodule

// File: rtl/flo_ser_idx.sv
module flo_ser_idx #(
  parameter int CHAIN_LEN = 34,
  localparam int IDX_W    = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHAIN_LEN - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr)        idx_d = '0;
    else if (shift) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

  // R6
  ser_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);

  // R6
  ser_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr && idx == LAST) |=> idx == '0);

endmodule

// File: rtl/flo_regs.sv
module flo_regs
  import flo_pkg::*;
#(
  parameter int OFS_W  = 17,
  parameter int BUS_W  = 18,
  parameter int DFLT_0 = 7,
  parameter int DFLT_1 = 31,
  parameter int DFLT_2 = 63,
  parameter int DFLT_3 = 127,
  localparam int LO_W  = (OFS_W + 1) / 2,
  localparam int HI_W  = OFS_W - LO_W,
  localparam int IDX_W = $clog2(2 * OFS_W),
  localparam int POS_W = $clog2(OFS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [1:0]       dflt_sel,
  input  logic             wr,
  input  logic             rd,
  input  slot_e            slot,
  input  logic [BUS_W-1:0] wdata,
  input  logic             ser_shift,
  input  logic [IDX_W-1:0] ser_idx,
  input  logic             ser_bit,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic [BUS_W-1:0] rdata
);

  logic [OFS_W-1:0] dflt;
  logic             ser_tgt;
  logic [POS_W-1:0] ser_pos;
  logic [OFS_W-1:0] ofs_q [2];

  always_comb begin
    unique case (dflt_sel)
      2'd0:    dflt = OFS_W'(DFLT_0);
      2'd1:    dflt = OFS_W'(DFLT_1);
      2'd2:    dflt = OFS_W'(DFLT_2);
      default: dflt = OFS_W'(DFLT_3);
    endcase
  end

  assign ser_tgt = (ser_idx >= IDX_W'(OFS_W));
  assign ser_pos = ser_tgt ? POS_W'(ser_idx - IDX_W'(OFS_W)) : POS_W'(ser_idx);

  for (genvar g = 0; g < 2; g++) begin : g_ofs
    localparam slot_e LO_SLOT = slot_e'(2'(2 * g));
    localparam slot_e HI_SLOT = slot_e'(2'(2 * g + 1));

    logic [OFS_W-1:0] q, d;

    always_comb begin
      d = q;
      if (init) begin
        d = dflt;
      end else if (wr) begin
        if (slot == LO_SLOT)      d[LO_W-1:0]     = wdata[LO_W-1:0];
        else if (slot == HI_SLOT) d[OFS_W-1:LO_W] = wdata[HI_W-1:0];
      end else if (ser_shift && (ser_tgt == 1'(g))) begin
        d[ser_pos] = ser_bit;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign ofs_q[g] = q;
  end

  logic [BUS_W-1:0] rd_q, rd_d;

  always_comb begin
    rd_d = rd_q;
    if (rd) begin
      unique case (slot)
        SLOT_EMPTY_LO: rd_d = BUS_W'(ofs_q[0][LO_W-1:0]);
        SLOT_EMPTY_HI: rd_d = BUS_W'(ofs_q[0][OFS_W-1:LO_W]);
        SLOT_FULL_LO:  rd_d = BUS_W'(ofs_q[1][LO_W-1:0]);
        default:       rd_d = BUS_W'(ofs_q[1][OFS_W-1:LO_W]);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign empty_ofs = ofs_q[0];
  assign full_ofs  = ofs_q[1];
  assign rdata     = rd_q;

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flo_pkg::*;
#(
  parameter int OFS_W  = 17,
  parameter int BUS_W  = 18,
  parameter int DFLT_0 = 7,
  parameter int DFLT_1 = 31,
  parameter int DFLT_2 = 63,
  parameter int DFLT_3 = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_init,
  input  logic             ptr_restart,
  input  logic [1:0]       dflt_sel,
  input  logic             ld_en,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] wdata,
  input  logic             ser_en,
  input  logic             ser_din,
  output logic [BUS_W-1:0] rdata,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);

  localparam int LO_W      = (OFS_W + 1) / 2;
  localparam int HI_W      = OFS_W - LO_W;
  localparam int CHAIN_LEN = 2 * OFS_W;
  localparam int IDX_W     = $clog2(CHAIN_LEN);

  logic             seq_clr, wr_go, rd_go, ser_go;
  slot_e            slot;
  logic [IDX_W-1:0] ser_idx;

  assign seq_clr = cfg_init | ptr_restart;
  assign wr_go   = ld_en & wr_en & ~seq_clr;
  assign rd_go   = ld_en & rd_en & ~wr_en & ~seq_clr;
  assign ser_go  = ser_en & ~ld_en & ~seq_clr;

  flo_rotor u_rotor (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (seq_clr),
    .step (wr_go | rd_go),
    .slot (slot)
  );

  flo_ser_idx #(.CHAIN_LEN(CHAIN_LEN)) u_ser (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (seq_clr),
    .shift(ser_go),
    .idx  (ser_idx)
  );

  flo_regs #(
    .OFS_W (OFS_W),
    .BUS_W (BUS_W),
    .DFLT_0(DFLT_0),
    .DFLT_1(DFLT_1),
    .DFLT_2(DFLT_2),
    .DFLT_3(DFLT_3)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (cfg_init),
    .dflt_sel (dflt_sel),
    .wr       (wr_go),
    .rd       (rd_go),
    .slot     (slot),
    .wdata    (wdata),
    .ser_shift(ser_go),
    .ser_idx  (ser_idx),
    .ser_bit  (ser_din),
    .empty_ofs(empty_ofs),
    .full_ofs (full_ofs),
    .rdata    (rdata)
  );

  // R2
  init_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_init |=> empty_ofs == full_ofs);

  // R3
  wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && slot == SLOT_EMPTY_LO) |=> empty_ofs[LO_W-1:0] == $past(wdata[LO_W-1:0]));

  // R5
  wr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && slot == SLOT_EMPTY_HI) |=> empty_ofs[OFS_W-1:LO_W] == $past(wdata[HI_W-1:0]));

  // R4
  rd_full_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && slot == SLOT_FULL_HI) |=> rdata == BUS_W'(full_ofs[OFS_W-1:LO_W]));

  // R7
  ser_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !wr_en && !cfg_init) |=> $stable(empty_ofs) && $stable(full_ofs));

  // R8
  restart_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_restart && !cfg_init) |=> $stable(empty_ofs) && $stable(full_ofs));

  // R9
  wr_rd_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_en) |=> $stable(rdata));

endmodule

// File: tb/sim_flag_offset_loader.sv
module sim_flag_offset_loader;

  localparam int OW = 17;
  localparam int BW = 18;
  localparam int LW = 9;
  localparam int CL = 2 * OW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_init, ptr_restart, ld_en, wr_en, rd_en, ser_en, ser_din;
  logic [1:0]    dflt_sel;
  logic [BW-1:0] wdata;
  logic [BW-1:0] rdata;
  logic [OW-1:0] empty_ofs, full_ofs;

  always #2 clk = ~clk;

  flag_offset_loader u0 (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .ptr_restart(ptr_restart),
    .dflt_sel(dflt_sel), .ld_en(ld_en), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .ser_en(ser_en), .ser_din(ser_din), .rdata(rdata),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [OW-1:0] m_e = '0, m_f = '0;
  logic [BW-1:0] m_rd = '0;
  int            m_rot = 0, m_sidx = 0;

  function automatic logic [OW-1:0] dflt_of(input int s);
    int sh;
    sh = (s == 0) ? 3 : s + 4;
    return OW'((1 << sh) - 1);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "empty_ofs", BW'(empty_ofs), BW'(m_e));
    chk(tag, "full_ofs",  BW'(full_ofs),  BW'(m_f));
    chk(tag, "rdata",     rdata,          m_rd);
  endtask

  // called at a falling edge; drives, lets one rising edge pass, updates model, compares
  task automatic cyc(input string tag, input bit i_init, input bit i_rst,
                     input bit i_ld, input bit i_wr, input bit i_rd,
                     input bit i_sen, input bit i_sb,
                     input logic [BW-1:0] d, input int sel);
    cfg_init = i_init; ptr_restart = i_rst; ld_en = i_ld; wr_en = i_wr;
    rd_en = i_rd; ser_en = i_sen; ser_din = i_sb; wdata = d;
    dflt_sel = 2'(sel);
    @(negedge clk);
    if (i_init) begin
      m_e = dflt_of(sel); m_f = dflt_of(sel); m_rot = 0; m_sidx = 0;
    end else if (i_rst) begin
      m_rot = 0; m_sidx = 0;
    end else if (i_ld && i_wr) begin
      case (m_rot)
        0: m_e[LW-1:0]  = d[LW-1:0];
        1: m_e[OW-1:LW] = d[OW-LW-1:0];
        2: m_f[LW-1:0]  = d[LW-1:0];
        default: m_f[OW-1:LW] = d[OW-LW-1:0];
      endcase
      m_rot = (m_rot + 1) % 4;
    end else if (i_ld && i_rd) begin
      case (m_rot)
        0: m_rd = BW'(m_e[LW-1:0]);
        1: m_rd = BW'(m_e[OW-1:LW]);
        2: m_rd = BW'(m_f[LW-1:0]);
        default: m_rd = BW'(m_f[OW-1:LW]);
      endcase
      m_rot = (m_rot + 1) % 4;
    end else if (i_sen && !i_ld) begin
      if (m_sidx < OW) m_e[m_sidx] = i_sb;
      else             m_f[m_sidx - OW] = i_sb;
      m_sidx = (m_sidx + 1) % CL;
    end
    compare(tag);
  endtask

  task automatic wr(input string tag, input logic [BW-1:0] d);
    cyc(tag, 0, 0, 1, 1, 0, 0, 0, d, 0);
  endtask

  task automatic rd(input string tag);
    cyc(tag, 0, 0, 1, 0, 1, 0, 0, '0, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    cfg_init = 0; ptr_restart = 0; ld_en = 0; wr_en = 0; rd_en = 0;
    ser_en = 0; ser_din = 0; wdata = '0; dflt_sel = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    // R1: pointer starts at slot 0 after reset
    wr("R1", 18'h3_0155);
    rd("R1");

    // R2: every default selection
    for (int s = 0; s < 4; s++) cyc("R2", 1, 0, 0, 0, 0, 0, 0, '0, s);
    // R2: init beats a simultaneous write and serial bit
    cyc("R2", 1, 0, 1, 1, 0, 1, 1, 18'h3_FFFF, 1);

    // R3 R5: two full rotations, upper bus bits set to show they are ignored
    for (int k = 0; k < 8; k++) wr("R3", BW'(18'h3_FE00 | (k * 67 + 5)));
    wr("R5", 18'h3_FFFF);
    wr("R5", 18'h3_FF00);
    // R4: read all four halves twice (pointer sits at slot 2 here)
    for (int k = 0; k < 8; k++) rd("R4");

    // R10: read then write lands on following slot
    cyc("R8", 0, 1, 0, 0, 0, 0, 0, '0, 0);
    rd("R10");
    wr("R10", 18'h0_00AA);
    rd("R10");
    // R9: write and read together, rdata holds
    cyc("R9", 0, 0, 1, 1, 1, 0, 0, 18'h0_0123, 0);
    cyc("R9", 0, 0, 1, 1, 1, 0, 0, 18'h0_0077, 0);

    // R8: restart mid-rotation keeps offsets, next write goes to slot 0
    wr("R8", 18'h0_0011);
    cyc("R8", 0, 1, 0, 0, 0, 0, 0, '0, 0);
    wr("R8", 18'h0_01C3);

    // R6: serial chain, full length plus wrap
    cyc("R6", 1, 0, 0, 0, 0, 0, 0, '0, 0);
    for (int i = 0; i < CL + 3; i++)
      cyc("R6", 0, 0, 0, 0, 0, 1, 1'(((i * 5 + 3) % 7) > 2), '0, 0);
    // R7: serial request blocked while ld_en is high
    for (int i = 0; i < 4; i++) cyc("R7", 0, 0, 1, 0, 0, 1, 1'(i & 1), '0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 1, '0, 0);
    // R8: restart of the serial position mid-chain
    cyc("R8", 0, 1, 0, 0, 0, 1, 0, '0, 0);
    for (int i = 0; i < 5; i++) cyc("R6", 0, 0, 0, 0, 0, 1, 1'(i % 2 == 0), '0, 0);
    for (int k = 0; k < 4; k++) rd("R4");

    summary();
  end

endmodule